// File: doc/BRIEF.md
# RV32I Base Instruction Decoder

This block turns one 32-bit base-integer RISC-V instruction word into the pieces an execution stage needs. It names the operation, pulls out the three register indices and the shift amount, and builds a sign-extended immediate together with a code that names which immediate layout was used. It is purely combinational. It has no clock, no state and no handshake. Every output follows `instr_i` within the same cycle.

The operation is found by a fixed-priority cascade of four mask classes. The cascade first compares the whole word. It then compares funct7, funct3 and the major opcode together. Next it compares funct3 and the opcode. Last, it compares the opcode alone. The first class that produces a hit wins. A word that produces no hit in any class raises `illegal_o` and drives the "none" operation code. Register and shift fields are always taken from their fixed bit positions, whatever the operation is. An upstream fetch stage drives the word, and a downstream register stage samples the outputs.

Top module: `rv32i_decoder`

## Requirements
- R1: The word 0x00000073 decodes as ecall (op 39) and the word 0x00100073 decodes as ebreak (op 40). Any other word whose bits [6:0] are 0x73 is illegal.
- R2: The funct7/funct3/opcode class uses funct7 = bits [31:25], funct3 = bits [14:12] and opcode = bits [6:0].
  - For opcode 0x33 with funct7 0x00, funct3 values 0 to 7 give add, sll, slt, sltu, xor, srl, or and and.
  - For opcode 0x33 with funct7 0x20, funct3 0 gives sub and funct3 5 gives sra.
  - For opcode 0x13, funct3 1 with funct7 0x00 gives slli. funct3 5 gives srli with funct7 0x00 and srai with funct7 0x20.
  - Any other funct7 value on these opcode/funct3 pairs is illegal.
- R3: The funct3/opcode class ignores bits [31:25], [24:15] and [11:7].
  - Opcode 0x63: funct3 values {0,1,4,5,6,7} give beq, bne, blt, bge, bltu, bgeu.
  - Opcode 0x67: funct3 0 gives jalr.
  - Opcode 0x13: funct3 values {0,2,3,4,6,7} give addi, slti, sltiu, xori, ori, andi.
  - Opcode 0x03: funct3 values {0,1,2,4,5} give lb, lh, lw, lbu, lhu.
  - Opcode 0x23: funct3 values {0,1,2} give sb, sh, sw.
  - Opcode 0x0f: funct3 0 gives fence.
  - Every other funct3 value on these opcodes is illegal.
- R4: Opcode 0x6f gives jal, 0x37 gives lui and 0x17 gives auipc. For these three, bits [31:7] have no effect on the operation.
- R5: A word that matches no class drives `illegal_o`=1, `op_o`=0, `imm_fmt_o`=0 and `imm_o`=0. Any word that matches a class drives `illegal_o`=0.
- R6: The operation codes are as follows.
  - 0 is none.
  - 1 lui, 2 auipc, 3 jal, 4 jalr.
  - 5 to 10 are beq, bne, blt, bge, bltu, bgeu.
  - 11 to 15 are lb, lh, lw, lbu, lhu.
  - 16 to 18 are sb, sh, sw.
  - 19 to 24 are addi, slti, sltiu, xori, ori, andi.
  - 25 to 27 are slli, srli, srai.
  - 28 to 37 are add, sub, sll, slt, sltu, xor, srl, sra, or, and.
  - 38 fence, 39 ecall, 40 ebreak.
- R7: For every word, including illegal ones, the outputs come from fixed bit positions: `rd_o` = bits [11:7], `rs1_o` = bits [19:15], `rs2_o` = bits [24:20] and `shamt_o` = bits [24:20].
- R8: The format codes are 0 none, 1 I, 2 S, 3 B, 4 U and 5 J.
  - jalr, the loads, the ALU-immediate operations and the immediate shifts use I.
  - Stores use S. Branches use B. lui and auipc use U. jal uses J.
  - Register-register operations, fence, ecall and ebreak use none.
- R9: The I immediate is bits [31:20] sign-extended to 32 bits.
- R10: The S immediate has imm[11:5] = bits [31:25] and imm[4:0] = bits [11:7], sign-extended from bit 31.
- R11: The B immediate has imm[12] = bit 31 (sign), imm[11] = bit 7, imm[10:5] = bits [30:25], imm[4:1] = bits [11:8] and imm[0] = 0.
- R12: The J immediate has imm[20] = bit 31 (sign), imm[19:12] = bits [19:12], imm[11] = bit 20, imm[10:1] = bits [30:21] and imm[0] = 0.
- R13: The U immediate is the word with bits [11:0] cleared.
- R14: When the format code is none, `imm_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| op_o | output | 6 | Operation code (R6), 0 when illegal |
| illegal_o | output | 1 | High when no mask class matched |
| imm_fmt_o | output | 3 | Immediate layout code (R8) |
| imm_o | output | 32 | Sign-extended immediate for the selected layout |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| shamt_o | output | 5 | Shift amount field |

## Verification
The hardest cases are the near misses. In these words a higher-priority class almost matches but fails, and the word must then fall through to a lower class or end up illegal. Examples are a system word with a nonzero rd, a shift-immediate with a stray funct7 bit, and a funct7 value such as 0x01 on a register-register opcode. The stimulus reaches these words by sweeping all 128 opcodes against all 8 funct3 values and five funct7 patterns. In that sweep, the exact-word cases and the extra system-word near misses are added directly. The register and immediate bits come from a shift-register sequence, so that the sign and field-splice positions see both values.

// File: rtl/rvdec_pkg.sv
`timescale 1ns/1ps
package rvdec_pkg;
  localparam int ILEN   = 32;
  localparam int XLEN   = 32;
  localparam int REGW   = 5;
  localparam int OPW    = 6;
  localparam int FMTW   = 3;
  localparam int NCLASS = 4;

  typedef enum logic [OPW-1:0] {
    OP_NONE  = 6'd0,
    OP_LUI   = 6'd1,  OP_AUIPC = 6'd2,  OP_JAL   = 6'd3,  OP_JALR  = 6'd4,
    OP_BEQ   = 6'd5,  OP_BNE   = 6'd6,  OP_BLT   = 6'd7,  OP_BGE   = 6'd8,
    OP_BLTU  = 6'd9,  OP_BGEU  = 6'd10,
    OP_LB    = 6'd11, OP_LH    = 6'd12, OP_LW    = 6'd13, OP_LBU   = 6'd14,
    OP_LHU   = 6'd15,
    OP_SB    = 6'd16, OP_SH    = 6'd17, OP_SW    = 6'd18,
    OP_ADDI  = 6'd19, OP_SLTI  = 6'd20, OP_SLTIU = 6'd21, OP_XORI  = 6'd22,
    OP_ORI   = 6'd23, OP_ANDI  = 6'd24,
    OP_SLLI  = 6'd25, OP_SRLI  = 6'd26, OP_SRAI  = 6'd27,
    OP_ADD   = 6'd28, OP_SUB   = 6'd29, OP_SLL   = 6'd30, OP_SLT   = 6'd31,
    OP_SLTU  = 6'd32, OP_XOR   = 6'd33, OP_SRL   = 6'd34, OP_SRA   = 6'd35,
    OP_OR    = 6'd36, OP_AND   = 6'd37,
    OP_FENCE = 6'd38, OP_ECALL = 6'd39, OP_EBREAK = 6'd40
  } op_e;

  typedef enum logic [FMTW-1:0] {
    FMT_NONE = 3'd0, FMT_I = 3'd1, FMT_S = 3'd2,
    FMT_B    = 3'd3, FMT_U = 3'd4, FMT_J = 3'd5
  } fmt_e;

  // Class masks, ordered by match priority.
  function automatic logic [ILEN-1:0] class_mask(input int cls);
    case (cls)
      0:       return 32'hffff_ffff;
      1:       return 32'hfe00_707f;
      2:       return 32'h0000_707f;
      default: return 32'h0000_007f;
    endcase
  endfunction

  function automatic op_e find_exact(input logic [ILEN-1:0] k);
    case (k)
      32'h0000_0073: return OP_ECALL;
      32'h0010_0073: return OP_EBREAK;
      default:       return OP_NONE;
    endcase
  endfunction

  function automatic op_e find_f7f3(input logic [ILEN-1:0] k);
    case (k)
      32'h0000_0033: return OP_ADD;
      32'h4000_0033: return OP_SUB;
      32'h0000_1033: return OP_SLL;
      32'h0000_2033: return OP_SLT;
      32'h0000_3033: return OP_SLTU;
      32'h0000_4033: return OP_XOR;
      32'h0000_5033: return OP_SRL;
      32'h4000_5033: return OP_SRA;
      32'h0000_6033: return OP_OR;
      32'h0000_7033: return OP_AND;
      32'h0000_1013: return OP_SLLI;
      32'h0000_5013: return OP_SRLI;
      32'h4000_5013: return OP_SRAI;
      default:       return OP_NONE;
    endcase
  endfunction

  function automatic op_e find_f3(input logic [ILEN-1:0] k);
    case (k)
      32'h0000_0063: return OP_BEQ;
      32'h0000_1063: return OP_BNE;
      32'h0000_4063: return OP_BLT;
      32'h0000_5063: return OP_BGE;
      32'h0000_6063: return OP_BLTU;
      32'h0000_7063: return OP_BGEU;
      32'h0000_0067: return OP_JALR;
      32'h0000_0013: return OP_ADDI;
      32'h0000_2013: return OP_SLTI;
      32'h0000_3013: return OP_SLTIU;
      32'h0000_4013: return OP_XORI;
      32'h0000_6013: return OP_ORI;
      32'h0000_7013: return OP_ANDI;
      32'h0000_0003: return OP_LB;
      32'h0000_1003: return OP_LH;
      32'h0000_2003: return OP_LW;
      32'h0000_4003: return OP_LBU;
      32'h0000_5003: return OP_LHU;
      32'h0000_0023: return OP_SB;
      32'h0000_1023: return OP_SH;
      32'h0000_2023: return OP_SW;
      32'h0000_000f: return OP_FENCE;
      default:       return OP_NONE;
    endcase
  endfunction

  function automatic op_e find_opc(input logic [ILEN-1:0] k);
    case (k)
      32'h0000_006f: return OP_JAL;
      32'h0000_0037: return OP_LUI;
      32'h0000_0017: return OP_AUIPC;
      default:       return OP_NONE;
    endcase
  endfunction

  function automatic fmt_e fmt_of(input op_e op);
    case (op)
      OP_JALR, OP_LB, OP_LH, OP_LW, OP_LBU, OP_LHU,
      OP_ADDI, OP_SLTI, OP_SLTIU, OP_XORI, OP_ORI, OP_ANDI,
      OP_SLLI, OP_SRLI, OP_SRAI:                      return FMT_I;
      OP_SB, OP_SH, OP_SW:                            return FMT_S;
      OP_BEQ, OP_BNE, OP_BLT, OP_BGE, OP_BLTU, OP_BGEU: return FMT_B;
      OP_LUI, OP_AUIPC:                               return FMT_U;
      OP_JAL:                                         return FMT_J;
      default:                                        return FMT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rvdec_class_match.sv
`timescale 1ns/1ps
module rvdec_class_match
  import rvdec_pkg::*;
#(
  parameter int CLS = 0
) (
  input  logic [ILEN-1:0] word_i,
  output op_e             op_o,
  output logic            hit_o
);
  localparam logic [ILEN-1:0] MASK = class_mask(CLS);

  logic [ILEN-1:0] key;
  assign key = word_i & MASK;

  generate
    if (CLS == 0) begin : g_exact
      assign op_o = find_exact(key);
    end else if (CLS == 1) begin : g_f7f3
      assign op_o = find_f7f3(key);
    end else if (CLS == 2) begin : g_f3
      assign op_o = find_f3(key);
    end else begin : g_opc
      assign op_o = find_opc(key);
    end
  endgenerate

  assign hit_o = (op_o != OP_NONE);

  // A hit in any class always carries a base opcode whose two low bits are set.
  always_comb begin
    p_hit_low_bits_r5: assert (!hit_o || (word_i[1:0] == 2'b11))
      else $error("class %0d hit on non-32-bit opcode", CLS);
  end
endmodule

// File: rtl/rvdec_match.sv
`timescale 1ns/1ps
module rvdec_match
  import rvdec_pkg::*;
(
  input  logic [ILEN-1:0] word_i,
  output op_e             op_o,
  output logic            illegal_o
);
  op_e  cls_op  [NCLASS];
  logic [NCLASS-1:0] cls_hit;

  for (genvar k = 0; k < NCLASS; k++) begin : g_cls
    rvdec_class_match #(.CLS(k)) u_cls (
      .word_i (word_i),
      .op_o   (cls_op[k]),
      .hit_o  (cls_hit[k])
    );
  end

  // First hitting class wins.
  always_comb begin
    logic found;
    found = 1'b0;
    op_o  = OP_NONE;
    for (int k = 0; k < NCLASS; k++) begin
      if (!found && cls_hit[k]) begin
        op_o  = cls_op[k];
        found = 1'b1;
      end
    end
  end

  assign illegal_o = ~|cls_hit;

  always_comb begin
    p_exact_is_system_r1: assert (!cls_hit[0] || (word_i[6:0] == 7'h73))
      else $error("exact class hit on a non-system opcode");
    p_exact_wins_r1: assert (!cls_hit[0] || (op_o == OP_ECALL) || (op_o == OP_EBREAK))
      else $error("exact class hit was not given priority");
  end
endmodule

// File: rtl/rvdec_fields.sv
`timescale 1ns/1ps
module rvdec_fields
  import rvdec_pkg::*;
(
  input  logic [ILEN-1:0] word_i,
  output logic [REGW-1:0] rd_o,
  output logic [REGW-1:0] rs1_o,
  output logic [REGW-1:0] rs2_o,
  output logic [REGW-1:0] shamt_o,
  output logic [XLEN-1:0] imm_i_o,
  output logic [XLEN-1:0] imm_s_o,
  output logic [XLEN-1:0] imm_b_o,
  output logic [XLEN-1:0] imm_u_o,
  output logic [XLEN-1:0] imm_j_o
);
  localparam int EXT12 = XLEN - 12;
  localparam int EXT13 = XLEN - 13;
  localparam int EXT21 = XLEN - 21;

  logic sgn;
  assign sgn = word_i[31];

  assign rd_o    = word_i[11:7];
  assign rs1_o   = word_i[19:15];
  assign rs2_o   = word_i[24:20];
  assign shamt_o = word_i[24:20];

  assign imm_i_o = {{EXT12{sgn}}, word_i[31:20]};
  assign imm_s_o = {{EXT12{sgn}}, word_i[31:25], word_i[11:7]};
  assign imm_b_o = {{EXT13{sgn}}, sgn, word_i[7], word_i[30:25], word_i[11:8], 1'b0};
  assign imm_u_o = {word_i[31:12], 12'b0};
  assign imm_j_o = {{EXT21{sgn}}, sgn, word_i[19:12], word_i[20], word_i[30:21], 1'b0};

  always_comb begin
    p_branch_even_r11: assert (imm_b_o[0] == 1'b0) else $error("B immediate odd");
    p_jump_even_r12:   assert (imm_j_o[0] == 1'b0) else $error("J immediate odd");
    p_upper_clear_r13: assert (imm_u_o[11:0] == '0) else $error("U immediate low bits set");
  end
endmodule

// File: rtl/rvdec_immsel.sv
`timescale 1ns/1ps
module rvdec_immsel
  import rvdec_pkg::*;
(
  input  fmt_e            fmt_i,
  input  logic [XLEN-1:0] imm_i_i,
  input  logic [XLEN-1:0] imm_s_i,
  input  logic [XLEN-1:0] imm_b_i,
  input  logic [XLEN-1:0] imm_u_i,
  input  logic [XLEN-1:0] imm_j_i,
  output logic [XLEN-1:0] imm_o
);
  always_comb begin
    case (fmt_i)
      FMT_I:   imm_o = imm_i_i;
      FMT_S:   imm_o = imm_s_i;
      FMT_B:   imm_o = imm_b_i;
      FMT_U:   imm_o = imm_u_i;
      FMT_J:   imm_o = imm_j_i;
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/rv32i_decoder.sv
`timescale 1ns/1ps
module rv32i_decoder
  import rvdec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [5:0]  op_o,
  output logic        illegal_o,
  output logic [2:0]  imm_fmt_o,
  output logic [31:0] imm_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [4:0]  shamt_o
);
  op_e             op;
  fmt_e            fmt;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  rvdec_match u_match (
    .word_i    (instr_i),
    .op_o      (op),
    .illegal_o (illegal_o)
  );

  assign fmt = fmt_of(op);

  rvdec_fields u_fields (
    .word_i  (instr_i),
    .rd_o    (rd_o),
    .rs1_o   (rs1_o),
    .rs2_o   (rs2_o),
    .shamt_o (shamt_o),
    .imm_i_o (imm_i),
    .imm_s_o (imm_s),
    .imm_b_o (imm_b),
    .imm_u_o (imm_u),
    .imm_j_o (imm_j)
  );

  rvdec_immsel u_immsel (
    .fmt_i   (fmt),
    .imm_i_i (imm_i),
    .imm_s_i (imm_s),
    .imm_b_i (imm_b),
    .imm_u_i (imm_u),
    .imm_j_i (imm_j),
    .imm_o   (imm_o)
  );

  assign op_o      = op;
  assign imm_fmt_o = fmt;

  always_comb begin
    p_illegal_none_r5: assert (illegal_o == (op_o == 6'd0))
      else $error("illegal flag and op code disagree");
    p_illegal_nofmt_r5: assert (!illegal_o || (imm_fmt_o == 3'd0))
      else $error("illegal word carries a format");
    p_imm_zero_r14: assert ((imm_fmt_o != 3'd0) || (imm_o == '0))
      else $error("immediate nonzero with no format");
    p_upper_low_clear_r13: assert ((imm_fmt_o != 3'd4) || (imm_o[11:0] == '0))
      else $error("U immediate low bits set at output");
    p_store_sign_r10: assert ((imm_fmt_o != 3'd2) || (imm_o[31:11] == {21{instr_i[31]}}))
      else $error("S immediate sign extension wrong");
  end
endmodule

// File: tb/rv32i_decoder_tb_top.sv
`timescale 1ns/1ps
module rv32i_decoder_tb_top;
  logic        clk = 1'b0;
  logic [31:0] instr;
  logic [5:0]  op;
  logic        illegal;
  logic [2:0]  fmt;
  logic [31:0] imm;
  logic [4:0]  rd, rs1, rs2, shamt;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5679;

  always #2.5 clk = ~clk;

  rv32i_decoder dut_i (
    .instr_i   (instr),
    .op_o      (op),
    .illegal_o (illegal),
    .imm_fmt_o (fmt),
    .imm_o     (imm),
    .rd_o      (rd),
    .rs1_o     (rs1),
    .rs2_o     (rs2),
    .shamt_o   (shamt)
  );

  task automatic chk(input string req, input logic [31:0] w,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s word=%h actual=%h expected=%h", req, w, act, exp);
    end
  endtask

  // Reference: R2, R3, R4, R1 field-wise decode, R6 codes, R8 formats.
  function automatic void ref_dec(input logic [31:0] w, output int eop, output int efmt);
    logic [6:0] oc;
    logic [2:0] f3;
    logic [6:0] f7;
    oc = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
    eop = 0; efmt = 0;
    case (oc)
      7'h37: begin eop = 1; efmt = 4; end
      7'h17: begin eop = 2; efmt = 4; end
      7'h6f: begin eop = 3; efmt = 5; end
      7'h67: if (f3 == 0) begin eop = 4; efmt = 1; end
      7'h63: if (f3 != 2 && f3 != 3) begin
               eop = (f3 < 2) ? 5 + int'(f3) : 7 + int'(f3) - 4; efmt = 3;
             end
      7'h03: if (f3 < 3) begin eop = 11 + int'(f3); efmt = 1; end
             else if (f3 == 4 || f3 == 5) begin eop = 14 + int'(f3) - 4; efmt = 1; end
      7'h23: if (f3 < 3) begin eop = 16 + int'(f3); efmt = 2; end
      7'h13: begin
        case (f3)
          3'd0: eop = 19;
          3'd2: eop = 20;
          3'd3: eop = 21;
          3'd4: eop = 22;
          3'd6: eop = 23;
          3'd7: eop = 24;
          3'd1: eop = (f7 == 7'h00) ? 25 : 0;
          default: eop = (f7 == 7'h00) ? 26 : (f7 == 7'h20) ? 27 : 0;
        endcase
        efmt = (eop != 0) ? 1 : 0;
      end
      7'h33: begin
        if (f7 == 7'h00) begin
          case (f3)
            3'd0: eop = 28;
            3'd1: eop = 30;
            3'd2: eop = 31;
            3'd3: eop = 32;
            3'd4: eop = 33;
            3'd5: eop = 34;
            3'd6: eop = 36;
            default: eop = 37;
          endcase
        end else if (f7 == 7'h20) begin
          if (f3 == 0) eop = 29;
          else if (f3 == 5) eop = 35;
        end
      end
      7'h0f: if (f3 == 0) eop = 38;
      7'h73: begin
        if (w == 32'h0000_0073) eop = 39;
        else if (w == 32'h0010_0073) eop = 40;
      end
      default: eop = 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_imm(input logic [31:0] w, input int efmt);
    int v;
    case (efmt)
      1: begin v = int'(w[31:20]); if (w[31]) v -= 4096; end
      2: begin v = int'(w[31:25]) * 32 + int'(w[11:7]); if (w[31]) v -= 4096; end
      3: begin
           v = int'(w[7]) * 2048 + int'(w[30:25]) * 32 + int'(w[11:8]) * 2;
           if (w[31]) v -= 4096;
         end
      4: return w - {20'd0, w[11:0]};
      5: begin
           v = int'(w[19:12]) * 4096 + int'(w[20]) * 2048 + int'(w[30:21]) * 2;
           if (w[31]) v -= 1048576;
         end
      default: v = 0;
    endcase
    return 32'(v);
  endfunction

  task automatic apply_and_check(input logic [31:0] w);
    int eop, efmt;
    @(posedge clk);
    instr = w;
    @(negedge clk);
    ref_dec(w, eop, efmt);
    chk((eop inside {1,2,3}) ? "R4 op" : (eop >= 39) ? "R1 op" : "R2/R3 op R6",
        w, {26'd0, op}, 32'(eop));
    chk("R5 illegal", w, {31'd0, illegal}, {31'd0, (eop == 0)});
    chk("R8 fmt", w, {29'd0, fmt}, 32'(efmt));
    chk(efmt == 1 ? "R9 imm" : efmt == 2 ? "R10 imm" : efmt == 3 ? "R11 imm" :
        efmt == 4 ? "R13 imm" : efmt == 5 ? "R12 imm" : "R14 imm",
        w, imm, ref_imm(w, efmt));
    chk("R7 fields", w, {12'd0, rd, rs1, rs2, shamt},
        {12'd0, w[11:7], w[19:15], w[24:20], w[24:20]});
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    logic [6:0] f7s [5];
    f7s[0] = 7'h00; f7s[1] = 7'h20; f7s[2] = 7'h01; f7s[3] = 7'h7f; f7s[4] = 7'h40;
    instr = 32'h0;
    // Reset-state pattern: all-zero word is illegal (R5).
    apply_and_check(32'h0000_0000);
    // R1 exact words and near misses.
    apply_and_check(32'h0000_0073);
    apply_and_check(32'h0010_0073);
    apply_and_check(32'h0000_00f3);
    apply_and_check(32'h0020_0073);
    apply_and_check(32'h8000_0073);
    // R3 fence ignores upper bits; R4 jal/lui/auipc ignore all upper bits.
    apply_and_check(32'hfff0_000f);
    apply_and_check(32'hffff_ffef);
    apply_and_check(32'hffff_ffb7);
    apply_and_check(32'h8000_0017);
    // R11/R12 extremes.
    apply_and_check(32'h8000_0063);
    apply_and_check(32'h7fff_ff63);
    apply_and_check(32'h7fff_f06f);
    // Sweep: every opcode x funct3 x funct7 pattern, random register bits.
    for (int oc = 0; oc < 128; oc++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int k = 0; k < 5; k++) begin
          lfsr = step(lfsr);
          apply_and_check({f7s[k], lfsr[24:15], 3'(f3), lfsr[11:7], 7'(oc)});
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule